// File: doc/BRIEF.md
# Mixed-Access Status and Event Register Bank

This block is a compact memory-mapped register bank on a plain synchronous bus. The bus has an address, write data, a write strobe, a read strobe and registered read data. Each register is not a plain store. Every field follows one access rule and has one owner, hardware or software, so bus traffic has effects that depend on the field.

Five words are mapped. A software-owned control word holds, among other things, the interrupt enables. A status word combines a live busy flag driven by hardware with a done flag that hardware raises and software drops by writing a one. A pending-event word collects hardware events and is cleared one bit at a time by writing ones. An event log word latches hardware events and empties when it is read. A command word only produces one-cycle pulses toward hardware. An interrupt line shows whether any enabled event is pending.

Each cycle the bus strobes are decoded into one of four access kinds: `ACC_IDLE`, `ACC_WRITE`, `ACC_READ` or `ACC_RDWR`. The kind is chosen with a `unique case`, and the kind then gates every write side effect and every read side effect. No multi-cycle sequencing exists, so no transitions exist between these kinds: each cycle stands on its own.

Top module: `regbank_status`

## Requirements
- R1: After reset every stored field is 0, and `irq`, `cmd_pulse` and `rd_data` are 0.
- R2: Word address 0 (control) is read-write over all 32 bits. A read returns the value last written, and `rd_data` shows it one clock after the cycle in which `rd_en` is high.
- R3: Bit 0 of word address 1 (status) returns the level of `hw_busy` in the read cycle. Bus writes never affect it. Bits 31:2 of the status word always read 0.
- R4: Bit 1 of the status word is set by `hw_done_set`. A write with data bit 1 at 1 clears it. A write with data bit 1 at 0 leaves it unchanged.
- R5: Word address 2 (pending events, bits N_EVT-1:0) sets bit i when `hw_evt[i]` is high. A write clears every bit whose data bit is 1 and keeps every bit whose data bit is 0.
- R6: If a hardware set and a software clear (a clearing write or a clearing read) hit the same bit in the same cycle, the bit ends up set.
- R7: Word address 3 (event log, bits N_LOG-1:0) sets bit i when `hw_log[i]` is high. A read returns the current value and clears the word in the same access. Writes have no effect.
- R8: Word address 4 (command) always reads 0. A write drives `cmd_pulse` to write data bits N_CMD-1:0 for exactly the next cycle. After that `cmd_pulse` returns to 0.
- R9: `irq` is 1 exactly when some bit is 1 both in the pending word and in control bits N_EVT-1:0.
- R10: Reads of word addresses 5 and above return 0. Writes or reads there change no register.
- R11: `rd_data` changes only on the clock edge that follows a cycle with `rd_en` high. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W | Registered read data |
| hw_busy | input | 1 | Live busy level from hardware |
| hw_done_set | input | 1 | Sets the done flag |
| hw_evt | input | N_EVT | Per-bit pending-event set strobes |
| hw_log | input | N_LOG | Per-bit event-log set strobes |
| irq | output | 1 | Enabled pending events present |
| cmd_pulse | output | N_CMD | One-cycle command pulses |

## Verification
A wrong clear mask or a wrong priority in a field shows up at the next read of that word, one clock after `rd_en`, as a bit that stuck or vanished. It also shows up on `irq` in the cycle right after the offending access. A wrong read side effect on the event log shows up as a second read that returns a nonzero value. A command register that kept state shows up on `cmd_pulse` two cycles after the write. Every address, every field bit and every set-versus-clear collision is swept, so each such fault is seen within a few bus accesses.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    localparam int A_CTRL   = 0;
    localparam int A_STATUS = 1;
    localparam int A_PEND   = 2;
    localparam int A_EVLOG  = 3;
    localparam int A_CMD    = 4;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_READ  = 2'd2,
        ACC_RDWR  = 2'd3
    } acc_e;

    typedef struct packed {
        logic ctrl;
        logic status;
        logic pend;
        logic evlog;
        logic cmd;
    } hit_t;

endpackage

// File: rtl/regbank_evt_field.sv
module regbank_evt_field #(
    parameter int W      = 8,
    parameter bit CLR_WR = 1'b1,
    parameter bit CLR_RD = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic         wr_clr,
    input  logic [W-1:0] wdata,
    input  logic         rd_clr,
    output logic [W-1:0] q
);

    logic [W-1:0] clr_mask;
    logic [W-1:0] q_n;

    always_comb begin
        clr_mask = '0;
        if (CLR_WR && wr_clr) clr_mask = clr_mask | wdata;
        if (CLR_RD && rd_clr) clr_mask = '1;
        q_n = (q & ~clr_mask) | set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= q_n;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set != '0) |=> ((q & $past(set)) == $past(set)));  // R6

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((set == '0) && !wr_clr && !rd_clr) |=> $stable(q));  // R5

endmodule

// File: rtl/regbank_rd_mux.sv
module regbank_rd_mux
    import regbank_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int N_EVT  = 8,
    parameter int N_LOG  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_go,
    input  hit_t              hit,
    input  logic [DATA_W-1:0] ctrl,
    input  logic              busy,
    input  logic              done,
    input  logic [N_EVT-1:0]  pend,
    input  logic [N_LOG-1:0]  evlog,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] rd_next;

    always_comb begin
        rd_next = '0;
        if (hit.ctrl) begin
            rd_next = ctrl;
        end else if (hit.status) begin
            rd_next[0] = busy;
            rd_next[1] = done;
        end else if (hit.pend) begin
            rd_next[N_EVT-1:0] = pend;
        end else if (hit.evlog) begin
            rd_next[N_LOG-1:0] = evlog;
        end else if (hit.cmd) begin
            rd_next = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_go) rd_data <= rd_next;
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_go) |-> $stable(rd_data));  // R11

    AST_BUSY_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && hit.status) |=> (rd_data[0] == $past(busy)));  // R3

    AST_CMD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && hit.cmd) |=> (rd_data == '0));  // R8

endmodule

// File: rtl/regbank_status.sv
module regbank_status
    import regbank_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int N_EVT  = 8,
    parameter int N_LOG  = 8,
    parameter int N_CMD  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              hw_busy,
    input  logic              hw_done_set,
    input  logic [N_EVT-1:0]  hw_evt,
    input  logic [N_LOG-1:0]  hw_log,
    output logic              irq,
    output logic [N_CMD-1:0]  cmd_pulse
);

    acc_e              acc;
    hit_t              hit;
    logic              wr_go;
    logic              rd_go;
    logic [DATA_W-1:0] ctrl_q;
    logic              done_q;
    logic [N_EVT-1:0]  pend_q;
    logic [N_LOG-1:0]  evlog_q;

    // access kind decode
    always_comb begin
        unique case ({wr_en, rd_en})
            2'b00:   acc = ACC_IDLE;
            2'b10:   acc = ACC_WRITE;
            2'b01:   acc = ACC_READ;
            default: acc = ACC_RDWR;
        endcase
        wr_go = (acc == ACC_WRITE) || (acc == ACC_RDWR);
        rd_go = (acc == ACC_READ)  || (acc == ACC_RDWR);
    end

    // address decode
    always_comb begin
        hit = '0;
        unique case (addr)
            ADDR_W'(A_CTRL):   hit.ctrl   = 1'b1;
            ADDR_W'(A_STATUS): hit.status = 1'b1;
            ADDR_W'(A_PEND):   hit.pend   = 1'b1;
            ADDR_W'(A_EVLOG):  hit.evlog  = 1'b1;
            ADDR_W'(A_CMD):    hit.cmd    = 1'b1;
            default:           hit        = '0;
        endcase
    end

    // software-owned control word
    always_ff @(posedge clk) begin
        if (!rst_n)                ctrl_q <= '0;
        else if (wr_go && hit.ctrl) ctrl_q <= wdata;
    end

    // write-only command pulses
    always_ff @(posedge clk) begin
        if (!rst_n)                cmd_pulse <= '0;
        else if (wr_go && hit.cmd) cmd_pulse <= wdata[N_CMD-1:0];
        else                       cmd_pulse <= '0;
    end

    regbank_evt_field #(.W(1), .CLR_WR(1'b1), .CLR_RD(1'b0)) u_done (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (hw_done_set),
        .wr_clr (wr_go && hit.status),
        .wdata  (wdata[1]),
        .rd_clr (1'b0),
        .q      (done_q)
    );

    regbank_evt_field #(.W(N_EVT), .CLR_WR(1'b1), .CLR_RD(1'b0)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (hw_evt),
        .wr_clr (wr_go && hit.pend),
        .wdata  (wdata[N_EVT-1:0]),
        .rd_clr (1'b0),
        .q      (pend_q)
    );

    regbank_evt_field #(.W(N_LOG), .CLR_WR(1'b0), .CLR_RD(1'b1)) u_evlog (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (hw_log),
        .wr_clr (1'b0),
        .wdata  ('0),
        .rd_clr (rd_go && hit.evlog),
        .q      (evlog_q)
    );

    regbank_rd_mux #(.DATA_W(DATA_W), .N_EVT(N_EVT), .N_LOG(N_LOG)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_go   (rd_go),
        .hit     (hit),
        .ctrl    (ctrl_q),
        .busy    (hw_busy),
        .done    (done_q),
        .pend    (pend_q),
        .evlog   (evlog_q),
        .rd_data (rd_data)
    );

    assign irq = |(pend_q & ctrl_q[N_EVT-1:0]);

    AST_CMD_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pulse != '0) |-> $past(wr_go && hit.cmd));  // R8

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ctrl_q[N_EVT-1:0] != '0));  // R9

    AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && (hit == '0)) |=> $stable(ctrl_q));  // R10

endmodule

// File: tb/regbank_status_tb.sv
module regbank_status_tb;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;
    localparam int N_EVT  = 8;
    localparam int N_LOG  = 8;
    localparam int N_CMD  = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic              wr_en, rd_en;
    logic [DATA_W-1:0] rd_data;
    logic              hw_busy, hw_done_set;
    logic [N_EVT-1:0]  hw_evt;
    logic [N_LOG-1:0]  hw_log;
    logic              irq;
    logic [N_CMD-1:0]  cmd_pulse;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    regbank_status #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_EVT(N_EVT),
                     .N_LOG(N_LOG), .N_CMD(N_CMD)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
        .hw_busy(hw_busy), .hw_done_set(hw_done_set),
        .hw_evt(hw_evt), .hw_log(hw_log), .irq(irq), .cmd_pulse(cmd_pulse)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic wr(input int a, input logic [31:0] d);
        addr = ADDR_W'(a); wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        addr = ADDR_W'(a); rd_en = 1'b1;
        @(negedge clk);
        v = rd_data;
        rd_en = 1'b0;
    endtask

    task automatic evt(input logic [N_EVT-1:0] e);
        hw_evt = e;
        @(negedge clk);
        hw_evt = '0;
    endtask

    task automatic logev(input logic [N_LOG-1:0] e);
        hw_log = e;
        @(negedge clk);
        hw_log = '0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        rst_n = 1'b0; addr = '0; wdata = '0; wr_en = 1'b0; rd_en = 1'b0;
        hw_busy = 1'b0; hw_done_set = 1'b0; hw_evt = '0; hw_log = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 rd_data", rd_data, 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 cmd_pulse", 32'(cmd_pulse), 0);
        for (int a = 0; a < 5; a++) begin
            rd(a, v);
            chk("R1 register", v, 0);
        end

        // R2: read-write control word, walking ones and patterns
        for (int i = 0; i < 32; i++) begin
            wr(0, 32'h1 << i);
            rd(0, v);
            chk("R2 walk", v, 32'h1 << i);
        end
        wr(0, 32'hA5C3_0FF1); rd(0, v); chk("R2 pattern", v, 32'hA5C3_0FF1);
        wr(0, 32'hFFFF_FFFF); rd(0, v); chk("R2 ones", v, 32'hFFFF_FFFF);
        wr(0, 32'h0000_1234); rd(0, v); chk("R2 small", v, 32'h0000_1234);

        // R11: read data holds while idle
        @(negedge clk); @(negedge clk);
        chk("R11 hold", rd_data, 32'h0000_1234);
        wr(0, 32'h0);
        chk("R11 hold over write", rd_data, 32'h0000_1234);

        // R3: busy is live, writes ignored, upper bits zero
        hw_busy = 1'b1;
        rd(1, v); chk("R3 busy high", v, 32'h1);
        wr(1, 32'hFFFF_FFFC); rd(1, v); chk("R3 write ignored", v, 32'h1);
        hw_busy = 1'b0;
        rd(1, v); chk("R3 busy low", v, 32'h0);
        wr(1, 32'h1); rd(1, v); chk("R3 write one ignored", v, 32'h0);

        // R4: done flag
        hw_done_set = 1'b1; @(negedge clk); hw_done_set = 1'b0;
        rd(1, v); chk("R4 done set", v, 32'h2);
        wr(1, 32'hFFFF_FFFD); rd(1, v); chk("R4 zero keeps", v, 32'h2);
        wr(1, 32'h2); rd(1, v); chk("R4 one clears", v, 32'h0);
        // R6: done set and clear together
        hw_done_set = 1'b1; wr(1, 32'h2); hw_done_set = 1'b0;
        rd(1, v); chk("R6 done set wins", v, 32'h2);
        wr(1, 32'h2);

        // R5 and R9: per-bit pending sweep
        for (int e = 0; e < N_EVT; e++) begin
            evt(N_EVT'(1 << e));
            rd(2, v); chk("R5 set", v, 32'h1 << e);
            chk("R9 disabled", 32'(irq), 0);
            wr(0, ~(32'h1 << e));
            chk("R9 other enables", 32'(irq), 0);
            wr(0, 32'h1 << e);
            chk("R9 enabled", 32'(irq), 1);
            wr(2, ~(32'h1 << e)); rd(2, v); chk("R5 zero keeps", v, 32'h1 << e);
            wr(2, 32'h1 << e); rd(2, v); chk("R5 one clears", v, 0);
            chk("R9 drop", 32'(irq), 0);
        end
        wr(0, 32'h0F);
        evt(8'hA5);
        chk("R9 multi", 32'(irq), 1);
        wr(2, 32'h05); rd(2, v); chk("R5 partial clear", v, 32'hA0);
        chk("R9 masked", 32'(irq), 0);
        wr(2, 32'hFF);

        // R6: pending set wins over clear
        evt(8'h18);
        hw_evt = 8'h08; wr(2, 32'hFF); hw_evt = '0;
        rd(2, v); chk("R6 pend set wins", v, 32'h08);
        wr(2, 32'hFF);

        // R7: clear-on-read event log
        for (int i = 0; i < N_LOG; i++) begin
            logev(N_LOG'(1 << i));
            wr(3, 32'h0);
            rd(3, v); chk("R7 read value", v, 32'h1 << i);
            wr(3, 32'hFF);
            rd(3, v); chk("R7 cleared", v, 0);
        end
        logev(8'h01);
        hw_log = 8'h02; rd(3, v); hw_log = '0;
        chk("R6 log old value", v, 32'h01);
        rd(3, v); chk("R6 log set wins", v, 32'h02);
        rd(3, v); chk("R7 empty", v, 0);

        // R8: write-only command pulses
        for (int d = 0; d < 16; d++) begin
            wr(4, 32'hFFFF_FFF0 | 32'(d));
            chk("R8 pulse", 32'(cmd_pulse), 32'(d));
            @(negedge clk);
            chk("R8 one cycle", 32'(cmd_pulse), 0);
            rd(4, v); chk("R8 reads zero", v, 0);
        end

        // R10: unmapped addresses
        wr(0, 32'h55);
        evt(8'h3C);
        logev(8'h01);
        for (int a = 5; a < 16; a++) begin
            wr(a, 32'hFFFF_FFFF);
            rd(a, v); chk("R10 reads zero", v, 0);
            chk("R10 no pulse", 32'(cmd_pulse), 0);
        end
        rd(0, v); chk("R10 ctrl kept", v, 32'h55);
        rd(2, v); chk("R10 pend kept", v, 32'h3C);
        rd(3, v); chk("R10 log kept", v, 32'h01);
        chk("R9 mixed", 32'(irq), 1);

        finish_run();
    end

endmodule